// File: doc/BRIEF.md
# CAN Bit Stuffer with Arbitration Monitor

This block turns a frame description into the serial bit stream of a CAN data or remote frame and watches the bus while it transmits. A frame is handed over in one cycle on the load interface. The block then puts one bit on `tx_o` per bit period. The bit periods are set by the `sample_i` strobe, which marks the sample point. The stuffed part of the frame starts with the start-of-frame bit and ends with the last CRC bit. After it comes a fixed recessive tail. While the frame is being sent, each bit read back from the bus is compared with the bit that was driven. A recessive bit that the bus overrides with a dominant one, inside the arbitration window, ends the transmission.

A separate destuffer reads the bus bit at each strobe while `destuff_en_i` is high. It passes data bits on with a one-cycle valid pulse, drops stuff bits, and flags a violation of the stuffing rule. The frame parser that drives `destuff_en_i` keeps it high for exactly the stuffed region of a received frame.

The transmitter is a state machine with four states:
- TX_IDLE: waiting for a load.
- TX_FRAME: a frame bit is on the bus.
- TX_STUFF: a stuff bit is on the bus.
- TX_TAIL: the recessive tail is on the bus.

Its transitions are:
- load: TX_IDLE to TX_FRAME.
- next bit: to TX_FRAME.
- insert: to TX_STUFF.
- finish: to TX_TAIL.
- lose: back to TX_IDLE.
- done: TX_TAIL to TX_IDLE.

The receiver is a state machine with three states:
- RX_OFF: disabled or awaiting the first bit.
- RX_RUN: destuffing.
- RX_HALT: after an error.

Its transitions are:
- start: RX_OFF to RX_RUN.
- violate: RX_RUN to RX_HALT.
- disable: any state to RX_OFF when the enable falls.

Top module: `can_stuff_arb`

## Requirements
- R1: After reset, `tx_o` is 1 (recessive), and `busy_o`, `arb_lost_o`, `rx_valid_o` and `stuff_err_o` are 0.
- R2: A load in idle sends the unstuffed bits most significant first, starting in the cycle after the load. The bits are a dominant SOF, then the header, then the data bytes, then `crc_i[14:0]`.
  - The standard header is `id_i[10:0]`, RTR, 0, 0, `dlc_i[3:0]`.
  - The extended header is `id_i[28:18]`, 1, 1, `id_i[17:0]`, RTR, 0, 0, `dlc_i[3:0]`.
  - The byte count is `dlc_i`, capped at 8. It is 0 when `rtr_i` is 1.
  - The bytes are taken from `data_i`, starting at bit 63.
- R3: In the stuffed region, a bit of opposite value is inserted after every five equal consecutive bits. A stuff bit counts as the first bit of a new run, and one is also inserted after the last CRC bit when needed.
- R4: After the stuffed region, `tx_o` is recessive for 13 bit periods. `busy_o` then falls.
- R5: A recessive bit that samples dominant at slot 1 to 12 (standard) or 1 to 32 (extended) causes the following, from the cycle after that strobe: `arb_lost_o` goes to 1, `tx_o` stays recessive, and `busy_o` goes to 0. Slots count from SOF = 0 and include stuff bits. The next load clears `arb_lost_o`.
- R6: A dominant override beyond the window has no effect on the transmitted sequence or on `arb_lost_o`.
- R7: A load while `busy_o` is high is ignored.
- R8: While `destuff_en_i` is high, each strobed bus bit gives a one-cycle `rx_valid_o` pulse with `rx_bit_o`, except the bit after five equal bits, which is discarded.
- R9: A sixth equal bit raises `stuff_err_o` from that strobe until the next strobe, with no valid pulse. Later bits are ignored until `destuff_en_i` falls.
- R10: With `destuff_en_i` low, no valid pulse appears, and run counting restarts at the next enabled bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_i | input | 1 | Sample-point strobe, one pulse per bit period |
| load_i | input | 1 | Load the frame fields (taken only when idle) |
| ext_i | input | 1 | 1 = extended header, 0 = standard |
| rtr_i | input | 1 | Remote request bit |
| id_i | input | 29 | Identifier |
| dlc_i | input | 4 | Length code |
| data_i | input | 64 | Data bytes, first byte in bits 63:56 |
| crc_i | input | 15 | CRC field to append |
| rx_i | input | 1 | Bus bit at the sample point |
| destuff_en_i | input | 1 | Receive stuffed region active |
| tx_o | output | 1 | Transmit bit |
| busy_o | output | 1 | Transmission in progress |
| arb_lost_o | output | 1 | Arbitration lost on the last frame |
| rx_bit_o | output | 1 | Destuffed receive bit |
| rx_valid_o | output | 1 | One-cycle pulse: `rx_bit_o` is valid |
| stuff_err_o | output | 1 | Stuffing violation seen |

## Verification
The bench builds the block with its default windows of 12 and 32 slots and a 13-bit tail. With these values, every length code from 0 to 9 in both formats, one length code of 15, and remote frames fit in a short run, and each frame is fed back through the destuffer. Identifier and data patterns of all zeros and all ones produce long runs. These runs make the stuff bits land on the boundaries between fields and after the last CRC bit. The arbitration cases force dominant bits at slot 1, at the last recessive slot inside each window, and at the first recessive slot beyond it.

// File: rtl/can_stuff_pkg.sv
package can_stuff_pkg;

    localparam int ID_W       = 29;
    localparam int DLC_W      = 4;
    localparam int DATA_W     = 64;
    localparam int CRC_W      = 15;
    localparam int HDR_STD    = 19;   // SOF + standard header
    localparam int HDR_EXT    = 39;   // SOF + extended header
    localparam int FRAME_W    = HDR_EXT + DATA_W + CRC_W;
    localparam int CNT_W      = $clog2(FRAME_W + 1);
    localparam int RUN_W      = 3;
    localparam int RUN_LIMIT  = 5;
    localparam int MAX_BYTES  = 8;

    typedef struct packed {
        logic              ext;
        logic              rtr;
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
        logic [CRC_W-1:0]  crc;
    } frame_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_FRAME,
        TX_STUFF,
        TX_TAIL
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_OFF,
        RX_RUN,
        RX_HALT
    } rx_state_t;

endpackage

// File: rtl/can_frame_pack.sv
module can_frame_pack
    import can_stuff_pkg::*;
(
    input  frame_t             frame_i,
    output logic [FRAME_W-1:0] bits_o,
    output logic [CNT_W-1:0]   nbits_o
);

    localparam int TAIL_W = DATA_W + CRC_W;

    logic [DLC_W-1:0]   nbytes;
    logic [CNT_W-1:0]   dbits;
    logic [DATA_W-1:0]  keep;
    logic [TAIL_W-1:0]  tail;
    logic [HDR_STD-1:0] hdr_s;
    logic [HDR_EXT-1:0] hdr_e;

    always_comb begin
        if (frame_i.rtr)
            nbytes = '0;
        else if (frame_i.dlc > DLC_W'(MAX_BYTES))
            nbytes = DLC_W'(MAX_BYTES);
        else
            nbytes = frame_i.dlc;
        dbits = CNT_W'({nbytes, 3'b000});
        keep  = ~({DATA_W{1'b1}} >> dbits);
        tail  = {frame_i.data & keep, {CRC_W{1'b0}}}
              | ({frame_i.crc, {DATA_W{1'b0}}} >> dbits);
        hdr_s = {1'b0, frame_i.id[10:0], frame_i.rtr, 2'b00, frame_i.dlc};
        hdr_e = {1'b0, frame_i.id[28:18], 2'b11, frame_i.id[17:0],
                 frame_i.rtr, 2'b00, frame_i.dlc};
        if (frame_i.ext) begin
            bits_o  = {hdr_e, tail};
            nbits_o = CNT_W'(HDR_EXT) + dbits + CNT_W'(CRC_W);
        end else begin
            bits_o  = {hdr_s, tail, {(HDR_EXT-HDR_STD){1'b0}}};
            nbits_o = CNT_W'(HDR_STD) + dbits + CNT_W'(CRC_W);
        end
    end

endmodule

// File: rtl/can_tx_stuffer.sv
module can_tx_stuffer
    import can_stuff_pkg::*;
#(
    parameter int STD_WIN  = 12,
    parameter int EXT_WIN  = 32,
    parameter int TAIL_LEN = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_i,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] bits_i,
    input  logic [CNT_W-1:0]   nbits_i,
    input  logic               ext_i,
    input  logic               rx_i,
    output logic               tx_o,
    output logic               busy_o,
    output logic               arb_lost_o,
    output logic               in_region_o
);

    localparam int TAIL_W = $clog2(TAIL_LEN);
    localparam logic [CNT_W-1:0] SLOT_MAX = '1;

    tx_state_t          state_q, state_d;
    logic [FRAME_W-1:0] sreg_q;
    logic [CNT_W-1:0]   left_q, slot_q, win;
    logic [RUN_W-1:0]   run_q;
    logic [TAIL_W-1:0]  tail_q;
    logic               ext_q, tx_q, lost_q, lose;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        lose    = 1'b0;
        win     = ext_q ? CNT_W'(EXT_WIN) : CNT_W'(STD_WIN);
        unique case (state_q)
            TX_IDLE:  if (load_i) state_d = TX_FRAME;
            TX_FRAME, TX_STUFF: begin
                if (sample_i) begin
                    if (tx_q && !rx_i && slot_q <= win) begin
                        lose    = 1'b1;
                        state_d = TX_IDLE;
                    end else if (run_q == RUN_W'(RUN_LIMIT)) begin
                        state_d = TX_STUFF;
                    end else if (left_q != '0) begin
                        state_d = TX_FRAME;
                    end else begin
                        state_d = TX_TAIL;
                    end
                end
            end
            TX_TAIL:  if (sample_i && tail_q == '0) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            left_q <= '0;
            slot_q <= '0;
            run_q  <= '0;
            tail_q <= '0;
            ext_q  <= 1'b0;
            tx_q   <= 1'b1;
            lost_q <= 1'b0;
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    if (load_i) begin
                        sreg_q <= bits_i << 1;
                        tx_q   <= bits_i[FRAME_W-1];
                        left_q <= nbits_i - 1'b1;
                        run_q  <= RUN_W'(1);
                        slot_q <= '0;
                        ext_q  <= ext_i;
                        lost_q <= 1'b0;
                    end
                end
                TX_FRAME, TX_STUFF: begin
                    if (sample_i) begin
                        if (slot_q != SLOT_MAX) slot_q <= slot_q + 1'b1;
                        if (lose) begin
                            tx_q   <= 1'b1;
                            lost_q <= 1'b1;
                        end else if (run_q == RUN_W'(RUN_LIMIT)) begin
                            tx_q  <= ~tx_q;
                            run_q <= RUN_W'(1);
                        end else if (left_q != '0) begin
                            tx_q   <= sreg_q[FRAME_W-1];
                            sreg_q <= sreg_q << 1;
                            left_q <= left_q - 1'b1;
                            run_q  <= (sreg_q[FRAME_W-1] == tx_q) ? run_q + 1'b1
                                                                  : RUN_W'(1);
                        end else begin
                            tx_q   <= 1'b1;
                            tail_q <= TAIL_W'(TAIL_LEN - 1);
                        end
                    end
                end
                TX_TAIL: begin
                    if (sample_i && tail_q != '0) tail_q <= tail_q - 1'b1;
                end
                default: tx_q <= 1'b1;
            endcase
        end
    end

    assign tx_o        = tx_q;
    assign arb_lost_o  = lost_q;
    assign busy_o      = (state_q != TX_IDLE);
    assign in_region_o = (state_q == TX_FRAME) || (state_q == TX_STUFF);

endmodule

// File: rtl/can_rx_destuffer.sv
module can_rx_destuffer
    import can_stuff_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sample_i,
    input  logic en_i,
    input  logic rx_i,
    output logic bit_o,
    output logic valid_o,
    output logic err_o
);

    rx_state_t        state_q, state_d;
    logic [RUN_W-1:0] run_q;
    logic             prev_q, bit_q, valid_q, err_q, full;

    assign full = (run_q == RUN_W'(RUN_LIMIT));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_OFF;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = RX_OFF;
        end else begin
            unique case (state_q)
                RX_OFF:  if (sample_i) state_d = RX_RUN;
                RX_RUN:  if (sample_i && full && rx_i == prev_q) state_d = RX_HALT;
                RX_HALT: state_d = RX_HALT;
                default: state_d = RX_OFF;
            endcase
        end
    end

    // outputs and run tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= '0;
            prev_q  <= 1'b1;
            bit_q   <= 1'b1;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (sample_i) err_q <= 1'b0;
            if (en_i && sample_i) begin
                unique case (state_q)
                    RX_OFF: begin
                        valid_q <= 1'b1;
                        bit_q   <= rx_i;
                        prev_q  <= rx_i;
                        run_q   <= RUN_W'(1);
                    end
                    RX_RUN: begin
                        if (full) begin
                            if (rx_i == prev_q) begin
                                err_q <= 1'b1;
                            end else begin
                                prev_q <= rx_i;
                                run_q  <= RUN_W'(1);
                            end
                        end else begin
                            valid_q <= 1'b1;
                            bit_q   <= rx_i;
                            prev_q  <= rx_i;
                            run_q   <= (rx_i == prev_q) ? run_q + 1'b1 : RUN_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign bit_o   = bit_q;
    assign valid_o = valid_q;
    assign err_o   = err_q;

endmodule

// File: rtl/can_stuff_arb.sv
module can_stuff_arb
    import can_stuff_pkg::*;
#(
    parameter int STD_WIN  = 12,
    parameter int EXT_WIN  = 32,
    parameter int TAIL_LEN = 13
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sample_i,
    input  logic        load_i,
    input  logic        ext_i,
    input  logic        rtr_i,
    input  logic [28:0] id_i,
    input  logic [3:0]  dlc_i,
    input  logic [63:0] data_i,
    input  logic [14:0] crc_i,
    input  logic        rx_i,
    input  logic        destuff_en_i,
    output logic        tx_o,
    output logic        busy_o,
    output logic        arb_lost_o,
    output logic        rx_bit_o,
    output logic        rx_valid_o,
    output logic        stuff_err_o
);

    frame_t             frame;
    logic [FRAME_W-1:0] frame_bits;
    logic [CNT_W-1:0]   frame_nbits;
    logic               tx_in_region;

    assign frame = '{ext: ext_i, rtr: rtr_i, id: id_i, dlc: dlc_i,
                     data: data_i, crc: crc_i};

    can_frame_pack u_pack (
        .frame_i (frame),
        .bits_o  (frame_bits),
        .nbits_o (frame_nbits)
    );

    can_tx_stuffer #(
        .STD_WIN  (STD_WIN),
        .EXT_WIN  (EXT_WIN),
        .TAIL_LEN (TAIL_LEN)
    ) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_i    (sample_i),
        .load_i      (load_i),
        .bits_i      (frame_bits),
        .nbits_i     (frame_nbits),
        .ext_i       (ext_i),
        .rx_i        (rx_i),
        .tx_o        (tx_o),
        .busy_o      (busy_o),
        .arb_lost_o  (arb_lost_o),
        .in_region_o (tx_in_region)
    );

    can_rx_destuffer u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample_i),
        .en_i     (destuff_en_i),
        .rx_i     (rx_i),
        .bit_o    (rx_bit_o),
        .valid_o  (rx_valid_o),
        .err_o    (stuff_err_o)
    );

endmodule

// File: rtl/can_stuff_arb_chk.sv
module can_stuff_arb_chk (
    input logic clk,
    input logic rst_n,
    input logic sample_i,
    input logic destuff_en_i,
    input logic tx_o,
    input logic busy_o,
    input logic arb_lost_o,
    input logic rx_valid_o,
    input logic stuff_err_o,
    input logic tx_in_region
);

    logic [2:0] run_cnt;
    logic       last_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt  <= '0;
            last_bit <= 1'b1;
        end else if (sample_i) begin
            if (tx_in_region) begin
                run_cnt  <= (run_cnt != 0 && tx_o == last_bit) ? run_cnt + 3'd1 : 3'd1;
                last_bit <= tx_o;
            end else begin
                run_cnt <= '0;
            end
        end
    end

    a_r3_no_six_run: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= 3'd5);

    a_r4_idle_recessive: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> tx_o);

    a_r5_lost_recessive: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost_o) |-> (tx_o && !busy_o));

    a_r8_valid_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> $past(sample_i && destuff_en_i));

    a_r9_err_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stuff_err_o) |-> !rx_valid_o);

    a_r9_err_one_period: assert property (@(posedge clk) disable iff (!rst_n)
        (stuff_err_o && sample_i) |=> !stuff_err_o);

endmodule

bind can_stuff_arb can_stuff_arb_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_i     (sample_i),
    .destuff_en_i (destuff_en_i),
    .tx_o         (tx_o),
    .busy_o       (busy_o),
    .arb_lost_o   (arb_lost_o),
    .rx_valid_o   (rx_valid_o),
    .stuff_err_o  (stuff_err_o),
    .tx_in_region (tx_in_region)
);

// File: tb/can_stuff_arb_test.sv
module can_stuff_arb_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_i = 1'b0;
    logic        load_i = 1'b0;
    logic        ext_i = 1'b0;
    logic        rtr_i = 1'b0;
    logic [28:0] id_i = '0;
    logic [3:0]  dlc_i = '0;
    logic [63:0] data_i = '0;
    logic [14:0] crc_i = '0;
    logic        destuff_en_i = 1'b0;
    logic        force_dom = 1'b0;
    logic        rx_i;
    logic        tx_o, busy_o, arb_lost_o, rx_bit_o, rx_valid_o, stuff_err_o;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    bit ub [0:127];
    int un;
    bit sb [0:199];
    bit sst [0:199];
    int sn;

    always #5 clk = ~clk;

    assign rx_i = tx_o & ~force_dom;

    can_stuff_arb uut (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .load_i(load_i),
        .ext_i(ext_i), .rtr_i(rtr_i), .id_i(id_i), .dlc_i(dlc_i),
        .data_i(data_i), .crc_i(crc_i), .rx_i(rx_i), .destuff_en_i(destuff_en_i),
        .tx_o(tx_o), .busy_o(busy_o), .arb_lost_o(arb_lost_o),
        .rx_bit_o(rx_bit_o), .rx_valid_o(rx_valid_o), .stuff_err_o(stuff_err_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input bit b);
        ub[un] = b;
        un++;
    endtask

    // expected bit streams from the frame layout and stuffing rule
    task automatic build(input bit ext, input bit rtr, input logic [28:0] id,
                         input int dlc, input logic [63:0] data, input logic [14:0] crc);
        int nb;
        int run;
        bit prev;
        un = 0;
        push(1'b0);
        if (ext) begin
            for (int i = 28; i >= 18; i--) push(id[i]);
            push(1'b1); push(1'b1);
            for (int i = 17; i >= 0; i--) push(id[i]);
        end else begin
            for (int i = 10; i >= 0; i--) push(id[i]);
        end
        push(rtr);
        if (!ext) push(1'b0);
        push(1'b0);
        if (ext) push(1'b0);
        for (int i = 3; i >= 0; i--) push(dlc[i]);
        nb = rtr ? 0 : (dlc > 8 ? 8 : dlc);
        for (int i = 0; i < nb * 8; i++) push(data[63 - i]);
        for (int i = 14; i >= 0; i--) push(crc[i]);
        sn = 0;
        run = 0;
        prev = 1'b1;
        for (int i = 0; i < un; i++) begin
            sb[sn] = ub[i]; sst[sn] = 1'b0; sn++;
            if (run != 0 && ub[i] == prev) run++;
            else run = 1;
            prev = ub[i];
            if (run == 5) begin
                sb[sn] = ~prev; sst[sn] = 1'b1; sn++;
                prev = ~prev;
                run = 1;
            end
        end
    endtask

    task automatic send_frame(input bit ext, input bit rtr, input logic [28:0] id,
                              input int dlc, input logic [63:0] data, input logic [14:0] crc,
                              input int force_at, input bit exp_loss, input bit do_rx,
                              input bit mid_load);
        int ridx = 0;
        build(ext, rtr, id, dlc, data, crc);
        @(negedge clk);
        ext_i = ext; rtr_i = rtr; id_i = id; dlc_i = 4'(dlc); data_i = data; crc_i = crc;
        load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        chk(arb_lost_o == 1'b0, "R5 load clears lost", arb_lost_o, 0);
        chk(busy_o == 1'b1, "R2 busy after load", busy_o, 1);
        destuff_en_i = do_rx;
        for (int k = 0; k < sn; k++) begin
            chk(tx_o == sb[k], sst[k] ? "R3 stuff bit" : "R2 frame bit", tx_o, sb[k]);
            force_dom = (k == force_at);
            sample_i = 1'b1;
            if (mid_load && k == 5) begin
                load_i = 1'b1;
                id_i = ~id; data_i = ~data; dlc_i = 4'd1; ext_i = ~ext;
            end
            @(negedge clk);
            sample_i = 1'b0;
            load_i = 1'b0;
            force_dom = 1'b0;
            if (k == force_at) begin
                if (exp_loss) begin
                    chk(arb_lost_o == 1'b1, "R5 lost flag", arb_lost_o, 1);
                    chk(tx_o == 1'b1, "R5 recessive after loss", tx_o, 1);
                    chk(busy_o == 1'b0, "R5 stops", busy_o, 0);
                    destuff_en_i = 1'b0;
                    repeat (6) begin
                        @(negedge clk); sample_i = 1'b1;
                        @(negedge clk); sample_i = 1'b0;
                        chk(tx_o == 1'b1, "R5 stays recessive", tx_o, 1);
                    end
                    return;
                end else begin
                    chk(arb_lost_o == 1'b0, "R6 outside window", arb_lost_o, 0);
                end
            end
            if (do_rx) begin
                chk(stuff_err_o == 1'b0, "R8 no error", stuff_err_o, 0);
                if (sst[k]) begin
                    chk(rx_valid_o == 1'b0, "R8 stuff discarded", rx_valid_o, 0);
                end else begin
                    chk(rx_valid_o == 1'b1, "R8 valid", rx_valid_o, 1);
                    chk(rx_bit_o == ub[ridx], "R8 bit", rx_bit_o, ub[ridx]);
                    ridx++;
                end
            end
            repeat (2) @(negedge clk);
        end
        destuff_en_i = 1'b0;
        for (int t = 0; t < 13; t++) begin
            chk(tx_o == 1'b1 && busy_o == 1'b1, "R4 tail", {tx_o, busy_o}, 2'b11);
            sample_i = 1'b1;
            @(negedge clk);
            sample_i = 1'b0;
            chk(rx_valid_o == 1'b0, "R10 disabled", rx_valid_o, 0);
            repeat (2) @(negedge clk);
        end
        chk(busy_o == 1'b0, "R4 idle after tail", busy_o, 0);
        chk(arb_lost_o == 1'b0, "R6 no loss", arb_lost_o, 0);
    endtask

    task automatic rxb(input bit b, input bit ev, input bit ee, input string req);
        @(negedge clk);
        force_dom = ~b;
        sample_i = 1'b1;
        @(negedge clk);
        sample_i = 1'b0;
        force_dom = 1'b0;
        chk(rx_valid_o == ev, req, rx_valid_o, ev);
        if (ev) chk(rx_bit_o == b, req, rx_bit_o, b);
        chk(stuff_err_o == ee, req, stuff_err_o, ee);
    endtask

    initial begin
        logic [28:0] ids [0:2];
        logic [63:0] dats [0:2];
        logic [14:0] crcs [0:2];
        int w, kin, kout;
        ids[0] = '0;  ids[1] = '1;  ids[2] = 29'h0AAA_F0F0;
        dats[0] = '0; dats[1] = '1; dats[2] = 64'h0123_4567_89AB_CDEF;
        crcs[0] = '0; crcs[1] = '1; crcs[2] = 15'h4D7D;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tx_o == 1'b1, "R1 tx", tx_o, 1);
        chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
        chk(arb_lost_o == 1'b0, "R1 lost", arb_lost_o, 0);
        chk(rx_valid_o == 1'b0, "R1 valid", rx_valid_o, 0);
        chk(stuff_err_o == 1'b0, "R1 err", stuff_err_o, 0);

        // R2 R3 R4 R8 sweep over formats, length codes and patterns
        for (int e = 0; e < 2; e++)
            for (int d = 0; d < 10; d++)
                for (int p = 0; p < 3; p++)
                    send_frame(e[0], (d % 3) == 1, ids[p], d, dats[p], crcs[p], -1, 0, 1, 0);
        send_frame(1'b0, 1'b0, ids[2], 15, dats[2], crcs[2], -1, 0, 1, 0);
        send_frame(1'b1, 1'b1, ids[1], 15, dats[1], crcs[1], -1, 0, 1, 0);

        // R7 load while busy ignored
        send_frame(1'b0, 1'b0, ids[2], 3, dats[2], crcs[2], -1, 0, 1, 1);

        // R5 R6 arbitration window
        for (int e = 0; e < 2; e++) begin
            w = e ? 32 : 12;
            build(e[0], 1'b0, '1, 8, '1, '1);
            kin = -1;
            for (int k = 1; k <= w; k++) if (sb[k]) kin = k;
            kout = -1;
            for (int k = sn - 1; k > w; k--) if (sb[k]) kout = k;
            send_frame(e[0], 1'b0, '1, 8, '1, '1, 1, 1, 0, 0);
            send_frame(e[0], 1'b0, '1, 8, '1, '1, kin, 1, 0, 0);
            send_frame(e[0], 1'b0, '1, 8, '1, '1, kout, 0, 0, 0);
        end

        // R8 R9 R10 receiver alone (transmitter idle)
        destuff_en_i = 1'b1;
        for (int i = 0; i < 5; i++) rxb(1'b0, 1, 0, "R8 run of zeros");
        rxb(1'b1, 0, 0, "R8 stuff bit dropped");
        for (int i = 0; i < 4; i++) rxb(1'b1, 1, 0, "R8 run after stuff");
        rxb(1'b1, 0, 1, "R9 sixth equal bit");
        rxb(1'b0, 0, 0, "R9 halted and cleared");
        rxb(1'b1, 0, 0, "R9 still halted");
        @(negedge clk);
        destuff_en_i = 1'b0;
        rxb(1'b0, 0, 0, "R10 disabled");
        rxb(1'b0, 0, 0, "R10 disabled");
        @(negedge clk);
        destuff_en_i = 1'b1;
        for (int i = 0; i < 5; i++) rxb(1'b1, 1, 0, "R10 restart run");
        rxb(1'b1, 0, 1, "R9 sixth after restart");
        @(negedge clk);
        destuff_en_i = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        done = 1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule